// File: doc/BRIEF.md
# Random Generator Register Front End

This block sits between a 32-bit register port and a hardware entropy pipeline. It holds one 128-bit result as four readable data words. It keeps a status byte in which bit 0 says a result is waiting and bits 1 to 7 latch alarm events from the pipeline. The same register acknowledges: a write of ones clears the matching bits. Clearing the waiting bit frees the buffer, and the block then asks the pipeline for the next result.

A control word holds a generator enable and one interrupt enable for each alarm bit. These drive a level interrupt. The block also keeps the refill-cycle limits and the alarm threshold for the pipeline. For a bank of free-running oscillators it keeps four masks: run enable, detune, alarm mask and stopped flags. An oscillator that reports a stop is taken out of the enable mask and marked in the stopped mask. Software restarts it by writing the enable register again.

The port uses word addresses. The byte offset of each register divided by four gives its word index.

Top module: `rng_csr_front`

## Requirements
- R1: After reset the status, control, data, config, threshold and oscillator registers read zero, and gen_req and irq are low.
- R2: With the generator enabled (control bit 10) and no result waiting, a src_valid cycle stores src_data and sets status bit 0 on the next clock. Data word k (word indices 0 to 3) returns src_data[32k+31:32k].
- R3: While status bit 0 is set, src_valid is ignored and the data words keep their value.
- R4: A write to the status register (word 4) clears each bit written as 1 and leaves each bit written as 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R5: gen_req is high exactly when control bit 10 is set and status bit 0 is clear.
- R6: A pulse on evt_pulse[k], for k from 1 to 7, sets status bit k. The bits are: 1 oscillator shutdown, 2 stuck output, 3 noise, 4 run, 5 long run, 6 poker, 7 monobit.
- R7: irq is the OR over k = 1..7 of status bit k AND control bit k. Status bit 0 never raises irq.
- R8: The config register (word 6) keeps bits 31:16 as refill_max and bits 7:0 as refill_min; its other bits read zero. The threshold register (word 7) keeps bits 7:0.
- R9: When osc_stop[i] is high, bit i of the enable register (word 8) clears and bit i of the stopped register (word 11) sets on the next clock, and a stop wins over a write in the same cycle. Otherwise both registers, and the detune (word 9) and alarm mask (word 10) registers, take the written value.
- R10: Word 31 reads {4'b0, REV_MAJOR, REV_MINOR, REV_PATCH, 16'b0}. Word 30 reads NUM_OSC. All other undefined words read zero.
- R11: bus_rdata shows the addressed register on the clock after bus_rd and holds it until the next read. The control word reads back only bits 10 and 7:1.
- R12: Writing 0 to control clears the generator enable and every interrupt enable. src_valid is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_valid | input | 1 | Pipeline result valid |
| src_data | input | 128 | Pipeline result |
| evt_pulse | input | 7 | Alarm event pulses, index 7:1 |
| gen_req | output | 1 | Request for the next result |
| irq | output | 1 | Level interrupt |
| refill_max | output | 16 | Maximum refill cycles |
| refill_min | output | 8 | Minimum refill cycles |
| alarm_thresh | output | 8 | Alarm threshold |
| osc_stop | input | NUM_OSC | Oscillator stop reports |
| osc_en | output | NUM_OSC | Oscillator run enables |
| osc_detune | output | NUM_OSC | Oscillator detune mask |
| osc_alarm_mask | output | NUM_OSC | Oscillator alarm mask |

## Verification
The buffer is tried in four situations: a result offered while the buffer is empty, offered while a result waits, offered with the generator disabled, and offered after an acknowledge. These separate capture, hold and the enable gate. The status register gets writes of zeros, writes of ones, and a clear that lands in the same cycle as its event, which shows whether set or clear wins. The interrupt is checked with its enable on and with it off while the status bit stays set. The oscillator masks see a stop on some bits after an all-ones enable, then a rewrite. This tells the stop path apart from ordinary register storage.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned N_WORDS  = 4;
  localparam int unsigned AW       = 5;
  localparam int unsigned N_EVT    = 7;
  localparam int unsigned EN_BIT   = 10;

  typedef enum logic [AW-1:0] {
    WA_DATA0  = 5'd0,
    WA_DATA1  = 5'd1,
    WA_DATA2  = 5'd2,
    WA_DATA3  = 5'd3,
    WA_STATUS = 5'd4,
    WA_CTRL   = 5'd5,
    WA_CFG    = 5'd6,
    WA_THRESH = 5'd7,
    WA_OSCEN  = 5'd8,
    WA_DETUNE = 5'd9,
    WA_AMASK  = 5'd10,
    WA_STOPPED= 5'd11,
    WA_OPTS   = 5'd30,
    WA_REV    = 5'd31
  } word_addr_e;
endpackage

// File: rtl/rng_rst_sync.sv
module rng_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rng_data_buf.sv
module rng_data_buf #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_en,
  input  logic                src_valid,
  input  logic [WORDS*DW-1:0] src_data,
  input  logic                ack,
  output logic                ready,
  output logic [WORDS*DW-1:0] data
);
  logic load;
  logic ready_d, ready_q;

  always_comb begin
    load    = gen_en & ~ready_q & src_valid;
    ready_d = ready_q;
    if (load)     ready_d = 1'b1;
    else if (ack) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= src_data[w*DW +: DW];
    end
    assign data[w*DW +: DW] = word_q;
  end

  assign ready = ready_q;
endmodule

// File: rtl/rng_evt_status.sv
module rng_evt_status #(
  parameter int unsigned NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic [NEVT-1:0] clr,
  output logic [NEVT-1:0] sts
);
  for (genvar k = 0; k < NEVT; k++) begin : g_bit
    logic bit_d, bit_q;
    always_comb bit_d = (bit_q & ~clr[k]) | evt[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign sts[k] = bit_q;
  end
endmodule

// File: rtl/rng_osc_bank.sv
module rng_osc_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_reg,
  input  logic         wr_detune,
  input  logic         wr_amask,
  input  logic         wr_stopped,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] stop,
  output logic [N-1:0] en,
  output logic [N-1:0] detune,
  output logic [N-1:0] amask,
  output logic [N-1:0] stopped
);
  for (genvar i = 0; i < N; i++) begin : g_osc
    logic en_d, en_q, st_d, st_q, dt_q, am_q;

    always_comb begin
      en_d = en_q;
      if (wr_en_reg) en_d = wdata[i];
      if (stop[i])   en_d = 1'b0;
      st_d = st_q;
      if (wr_stopped) st_d = wdata[i];
      if (stop[i])    st_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        st_q <= 1'b0;
        dt_q <= 1'b0;
        am_q <= 1'b0;
      end else begin
        en_q <= en_d;
        st_q <= st_d;
        if (wr_detune) dt_q <= wdata[i];
        if (wr_amask)  am_q <= wdata[i];
      end
    end

    assign en[i]      = en_q;
    assign stopped[i] = st_q;
    assign detune[i]  = dt_q;
    assign amask[i]   = am_q;
  end
endmodule

// File: rtl/rng_csr_front.sv
module rng_csr_front
  import rng_csr_pkg::*;
#(
  parameter int unsigned NUM_OSC   = 8,
  parameter logic [3:0]  REV_MAJOR = 4'd1,
  parameter logic [3:0]  REV_MINOR = 4'd2,
  parameter logic [3:0]  REV_PATCH = 4'd3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [REG_W-1:0]           bus_wdata,
  output logic [REG_W-1:0]           bus_rdata,
  input  logic                       src_valid,
  input  logic [N_WORDS*REG_W-1:0]   src_data,
  input  logic [N_EVT:1]             evt_pulse,
  output logic                       gen_req,
  output logic                       irq,
  output logic [15:0]                refill_max,
  output logic [7:0]                 refill_min,
  output logic [7:0]                 alarm_thresh,
  input  logic [NUM_OSC-1:0]         osc_stop,
  output logic [NUM_OSC-1:0]         osc_en,
  output logic [NUM_OSC-1:0]         osc_detune,
  output logic [NUM_OSC-1:0]         osc_alarm_mask
);
  localparam int unsigned DATA_W = N_WORDS * REG_W;

  logic                rst_ni;
  logic                sel_sts, sel_ctrl, sel_cfg, sel_thr;
  logic                sel_oen, sel_det, sel_am, sel_stp;
  logic                ready;
  logic [DATA_W-1:0]   data_words;
  logic [N_EVT:1]      sts_evt;
  logic [N_EVT:1]      sts_clr;
  logic [NUM_OSC-1:0]  osc_stopped;

  logic                en_d, en_q;
  logic [N_EVT:1]      ie_d, ie_q;
  logic [15:0]         rmax_d, rmax_q;
  logic [7:0]          rmin_d, rmin_q;
  logic [7:0]          thr_d, thr_q;
  logic [REG_W-1:0]    rd_mux, rdata_d, rdata_q;

  rng_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  always_comb begin
    sel_sts  = bus_wr && (bus_addr == WA_STATUS);
    sel_ctrl = bus_wr && (bus_addr == WA_CTRL);
    sel_cfg  = bus_wr && (bus_addr == WA_CFG);
    sel_thr  = bus_wr && (bus_addr == WA_THRESH);
    sel_oen  = bus_wr && (bus_addr == WA_OSCEN);
    sel_det  = bus_wr && (bus_addr == WA_DETUNE);
    sel_am   = bus_wr && (bus_addr == WA_AMASK);
    sel_stp  = bus_wr && (bus_addr == WA_STOPPED);
    sts_clr  = sel_sts ? bus_wdata[N_EVT:1] : '0;
  end

  rng_data_buf #(.WORDS(N_WORDS), .DW(REG_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_ni),
    .gen_en    (en_q),
    .src_valid (src_valid),
    .src_data  (src_data),
    .ack       (sel_sts && bus_wdata[0]),
    .ready     (ready),
    .data      (data_words)
  );

  rng_evt_status #(.NEVT(N_EVT)) u_sts (
    .clk   (clk),
    .rst_n (rst_ni),
    .evt   (evt_pulse),
    .clr   (sts_clr),
    .sts   (sts_evt)
  );

  rng_osc_bank #(.N(NUM_OSC)) u_osc (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en_reg  (sel_oen),
    .wr_detune  (sel_det),
    .wr_amask   (sel_am),
    .wr_stopped (sel_stp),
    .wdata      (bus_wdata[NUM_OSC-1:0]),
    .stop       (osc_stop),
    .en         (osc_en),
    .detune     (osc_detune),
    .amask      (osc_alarm_mask),
    .stopped    (osc_stopped)
  );

  // configuration next state
  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    rmax_d = rmax_q;
    rmin_d = rmin_q;
    thr_d  = thr_q;
    if (sel_ctrl) begin
      en_d = bus_wdata[EN_BIT];
      ie_d = bus_wdata[N_EVT:1];
    end
    if (sel_cfg) begin
      rmax_d = bus_wdata[31:16];
      rmin_d = bus_wdata[7:0];
    end
    if (sel_thr) thr_d = bus_wdata[7:0];
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      WA_DATA0, WA_DATA1, WA_DATA2, WA_DATA3:
        rd_mux = data_words[bus_addr[1:0]*REG_W +: REG_W];
      WA_STATUS:  rd_mux[N_EVT:0] = {sts_evt, ready};
      WA_CTRL: begin
        rd_mux[EN_BIT]  = en_q;
        rd_mux[N_EVT:1] = ie_q;
      end
      WA_CFG:     rd_mux = {rmax_q, 8'h00, rmin_q};
      WA_THRESH:  rd_mux[7:0] = thr_q;
      WA_OSCEN:   rd_mux[NUM_OSC-1:0] = osc_en;
      WA_DETUNE:  rd_mux[NUM_OSC-1:0] = osc_detune;
      WA_AMASK:   rd_mux[NUM_OSC-1:0] = osc_alarm_mask;
      WA_STOPPED: rd_mux[NUM_OSC-1:0] = osc_stopped;
      WA_OPTS:    rd_mux[7:0] = 8'(NUM_OSC);
      WA_REV:     rd_mux = {4'h0, REV_MAJOR, REV_MINOR, REV_PATCH, 16'h0000};
      default:    rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= '0;
      rmax_q  <= '0;
      rmin_q  <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      ie_q    <= ie_d;
      rmax_q  <= rmax_d;
      rmin_q  <= rmin_d;
      thr_q   <= thr_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign gen_req      = en_q & ~ready;
  assign irq          = |(sts_evt & ie_q);
  assign refill_max   = rmax_q;
  assign refill_min   = rmin_q;
  assign alarm_thresh = thr_q;
endmodule

// File: rtl/rng_csr_front_chk.sv
module rng_csr_front_chk #(
  parameter int unsigned NUM_OSC = 8,
  parameter int unsigned DATA_W  = 128
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               ready,
  input logic [DATA_W-1:0]  data_words,
  input logic [7:1]         sts_evt,
  input logic               en_q,
  input logic               src_valid,
  input logic [DATA_W-1:0]  src_data,
  input logic               sel_sts,
  input logic [31:0]        bus_wdata,
  input logic [7:1]         evt_pulse,
  input logic               gen_req,
  input logic               irq,
  input logic [NUM_OSC-1:0] osc_stop,
  input logic [NUM_OSC-1:0] osc_en
);
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ready && en_q && src_valid) |=> (ready && data_words == $past(src_data))); // R2

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_ni)
    (ready && !(sel_sts && bus_wdata[0])) |=> (ready && $stable(data_words))); // R3

  AST_NO_REQ_READY: assert property (@(posedge clk) disable iff (!rst_ni)
    ready |-> !gen_req); // R5

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_pulse != '0) |=> ((sts_evt & $past(evt_pulse)) == $past(evt_pulse))); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (sts_evt != '0)); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (osc_stop != '0) |=> ((osc_en & $past(osc_stop)) == '0)); // R9
endmodule

bind rng_csr_front rng_csr_front_chk #(.NUM_OSC(NUM_OSC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .ready      (ready),
  .data_words (data_words),
  .sts_evt    (sts_evt),
  .en_q       (en_q),
  .src_valid  (src_valid),
  .src_data   (src_data),
  .sel_sts    (sel_sts),
  .bus_wdata  (bus_wdata),
  .evt_pulse  (evt_pulse),
  .gen_req    (gen_req),
  .irq        (irq),
  .osc_stop   (osc_stop),
  .osc_en     (osc_en)
);

// File: tb/rng_csr_front_tb.sv
module rng_csr_front_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         src_valid = 1'b0;
  logic [127:0] src_data = '0;
  logic [7:1]   evt_pulse = '0;
  logic         gen_req, irq;
  logic [15:0]  refill_max;
  logic [7:0]   refill_min, alarm_thresh;
  logic [N-1:0] osc_stop = '0;
  logic [N-1:0] osc_en, osc_detune, osc_alarm_mask;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rng_csr_front #(.NUM_OSC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_valid(src_valid), .src_data(src_data), .evt_pulse(evt_pulse),
    .gen_req(gen_req), .irq(irq), .refill_max(refill_max),
    .refill_min(refill_min), .alarm_thresh(alarm_thresh),
    .osc_stop(osc_stop), .osc_en(osc_en), .osc_detune(osc_detune),
    .osc_alarm_mask(osc_alarm_mask)
  );

  // behavioural reference model
  logic         m_ready, m_en;
  logic [7:1]   m_sts, m_ie;
  logic [127:0] m_data;
  logic [15:0]  m_rmax;
  logic [7:0]   m_rmin, m_thr;
  logic [N-1:0] m_oen, m_det, m_am, m_stp;
  logic [31:0]  m_rdata;

  function automatic logic [31:0] m_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      5'd0: r = m_data[31:0];
      5'd1: r = m_data[63:32];
      5'd2: r = m_data[95:64];
      5'd3: r = m_data[127:96];
      5'd4: r[7:0] = {m_sts, m_ready};
      5'd5: begin r[10] = m_en; r[7:1] = m_ie; end
      5'd6: r = {m_rmax, 8'h00, m_rmin};
      5'd7: r[7:0] = m_thr;
      5'd8: r[N-1:0] = m_oen;
      5'd9: r[N-1:0] = m_det;
      5'd10: r[N-1:0] = m_am;
      5'd11: r[N-1:0] = m_stp;
      5'd30: r = N;
      5'd31: r = 32'h0123_0000;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready = 0; m_en = 0; m_sts = '0; m_ie = '0; m_data = '0;
      m_rmax = '0; m_rmin = '0; m_thr = '0; m_oen = '0; m_det = '0;
      m_am = '0; m_stp = '0; m_rdata = '0;
    end else begin
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (m_ready) begin
        if (bus_wr && bus_addr == 5'd4 && bus_wdata[0]) m_ready = 0;
      end else if (m_en && src_valid) begin
        m_ready = 1;
        m_data  = src_data;
      end
      if (bus_wr && bus_addr == 5'd4) m_sts = m_sts & ~bus_wdata[7:1];
      m_sts = m_sts | evt_pulse;
      if (bus_wr && bus_addr == 5'd5) begin m_en = bus_wdata[10]; m_ie = bus_wdata[7:1]; end
      if (bus_wr && bus_addr == 5'd6) begin m_rmax = bus_wdata[31:16]; m_rmin = bus_wdata[7:0]; end
      if (bus_wr && bus_addr == 5'd7) m_thr = bus_wdata[7:0];
      if (bus_wr && bus_addr == 5'd8) m_oen = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 5'd9) m_det = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 5'd10) m_am = bus_wdata[N-1:0];
      if (bus_wr && bus_addr == 5'd11) m_stp = bus_wdata[N-1:0];
      m_oen = m_oen & ~osc_stop;
      m_stp = m_stp | osc_stop;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison of the output pins against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 gen_req", gen_req, m_en & ~m_ready);
      chk("R7 irq", irq, |(m_sts & m_ie));
      chk("R8 R9 outputs", {refill_max, refill_min, alarm_thresh, osc_en, osc_detune, osc_alarm_mask},
          {m_rmax, m_rmin, m_thr, m_oen, m_det, m_am});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk({tag, " R11 model"}, bus_rdata, m_rdata);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic offer(input logic [127:0] d);
    src_valid = 1; src_data = d;
    @(negedge clk);
    src_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    rd(5'd4, 32'h0, "R1 status");
    rd(5'd5, 32'h0, "R1 control");
    rd(5'd0, 32'h0, "R1 data0");
    rd(5'd8, 32'h0, "R1 oscen");
    chk("R1 gen_req irq", {gen_req, irq}, 2'b00);

    wr(5'd5, 32'h0000_04FE);
    chk("R5 request on enable", gen_req, 1'b1);
    rd(5'd5, 32'h0000_04FE, "R11 control readback");
    offer(128'h4444_4444_3333_3333_2222_2222_1111_1111);
    chk("R5 request drops", gen_req, 1'b0);
    rd(5'd0, 32'h1111_1111, "R2 word0");
    rd(5'd1, 32'h2222_2222, "R2 word1");
    rd(5'd2, 32'h3333_3333, "R2 word2");
    rd(5'd3, 32'h4444_4444, "R2 word3");
    rd(5'd4, 32'h1, "R2 ready");

    offer(128'hDEAD);
    rd(5'd0, 32'h1111_1111, "R3 hold");
    wr(5'd4, 32'h0);
    rd(5'd4, 32'h1, "R4 zero write");
    wr(5'd4, 32'h1);
    rd(5'd4, 32'h0, "R4 ack ready");
    chk("R5 request after ack", gen_req, 1'b1);
    offer(128'hA5A5_0000_0000_0000_0000_0000_0000_BEEF);
    rd(5'd0, 32'h0000_BEEF, "R2 second result");
    wr(5'd4, 32'h1);

    evt_pulse = 7'b0000100;  // status bit 3
    @(negedge clk);
    evt_pulse = '0;
    chk("R6 R7 irq on noise", irq, 1'b1);
    rd(5'd4, 32'h08, "R6 bit3");
    wr(5'd5, 32'h0000_04F6);
    chk("R7 masked", irq, 1'b0);
    rd(5'd4, 32'h08, "R7 bit kept");
    bus_wr = 1; bus_addr = 5'd4; bus_wdata = 32'h08; evt_pulse = 7'b0000100;
    @(negedge clk);
    bus_wr = 0; evt_pulse = '0;
    rd(5'd4, 32'h08, "R4 set wins");
    wr(5'd4, 32'hFF);
    evt_pulse = 7'b1000001;  // bits 7 and 1
    @(negedge clk);
    evt_pulse = '0;
    rd(5'd4, 32'h82, "R6 bits 7 1");
    chk("R7 irq bit7", irq, 1'b1);
    wr(5'd4, 32'hFF);

    wr(5'd5, 32'h0);
    chk("R12 irq and request off", {gen_req, irq}, 2'b00);
    offer(128'h77);
    rd(5'd4, 32'h0, "R12 ignored");
    rd(5'd0, 32'h0000_BEEF, "R12 data kept");

    wr(5'd6, 32'hFFFF_FFFF);
    rd(5'd6, 32'hFFFF_00FF, "R8 config");
    chk("R8 refill pins", {refill_max, refill_min}, {16'hFFFF, 8'hFF});
    wr(5'd7, 32'h0000_01A5);
    rd(5'd7, 32'hA5, "R8 threshold");

    wr(5'd8, 32'hFFFF_FFFF);
    wr(5'd9, 32'h3C);
    wr(5'd10, 32'hC3);
    osc_stop = 8'h05;
    @(negedge clk);
    osc_stop = '0;
    chk("R9 stop clears enable", osc_en, 8'hFA);
    rd(5'd11, 32'h05, "R9 stopped");
    bus_wr = 1; bus_addr = 5'd8; bus_wdata = 32'hFF; osc_stop = 8'h10;
    @(negedge clk);
    bus_wr = 0; osc_stop = '0;
    chk("R9 stop beats write", osc_en, 8'hEF);
    wr(5'd11, 32'h0);
    rd(5'd11, 32'h0, "R9 stopped cleared");
    wr(5'd8, 32'hFF);
    chk("R9 restart", osc_en, 8'hFF);

    rd(5'd31, 32'h0123_0000, "R10 revision");
    rd(5'd30, 32'd8, "R10 options");
    rd(5'd12, 32'h0, "R10 undefined");
    rd(5'd20, 32'h0, "R10 undefined");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule